// File: doc/BRIEF.md
# Register Rename Map with Reorder-Buffer Tags

This block sits beside the architectural register file and tracks, for every architectural register, whether the file holds the newest value. When an instruction in flight will produce a newer value, the block records the reorder-buffer entry number (the tag) of that producer. Decode reads each source register through the map. The answer is either "free", meaning the register-file value returned alongside is current, or "pending", together with the tag to look up in the reorder buffer.

Decode also renames each destination register to the tag of its freshly allocated reorder-buffer entry. The commit port writes retired results into the register file. It frees a register only when the retiring entry is still the register's newest producer, so that a younger writer keeps ownership. A flush discards every pending mapping and leaves the committed values in place.

Top module: `rename_map`

## Requirements
- R1: After reset every register reads as free (`rs_busy_o`=0, `rs_tag_o`=0) with register value 0, and a reset applied mid-run discards pending mappings and committed values alike.
- R2: A read of a free register returns busy 0, tag 0 and the register-file value on the same cycle, combinationally from `rs_idx_i`.
- R3: A rename (`ren_valid_i`=1, no flush) makes register `ren_idx_i` read busy with tag `ren_tag_i` from the next cycle on. A later rename of the same register replaces the tag, so the younger producer owns it.
- R4: Reads reflect the table as it stood at the start of the cycle, so a source read of the register being renamed in that same cycle returns the older mapping.
- R5: A commit whose tag equals the stored tag of a busy register makes that register free on the next cycle, with the committed data as its value.
- R6: A commit whose tag differs from the stored tag of a busy register writes the data but leaves the register busy with its existing tag.
- R7: When a rename and a commit name the same register in the same cycle, the rename wins: the register reads busy with the new tag and holds the committed data.
- R8: A flush makes every register free on the next cycle and keeps the register values. A rename presented in the same cycle is dropped.
- R9: Commit data is always written into the register value, including when the register is already free and when a flush is presented in the same cycle.
- R10: The two read ports work independently and may name the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard every pending mapping |
| rs_idx_i | input | 2x5 | Source register index for each read port |
| rs_busy_o | output | 2 | 1 = value pending in the reorder buffer |
| rs_tag_o | output | 2x4 | Producer tag when busy, otherwise 0 |
| rs_data_o | output | 2x32 | Register-file value of the indexed register |
| ren_valid_i | input | 1 | Rename a destination register this cycle |
| ren_idx_i | input | 5 | Destination register being renamed |
| ren_tag_i | input | 4 | Newly allocated reorder-buffer entry tag |
| cmt_valid_i | input | 1 | A reorder-buffer entry retires this cycle |
| cmt_idx_i | input | 5 | Destination register of the retiring entry |
| cmt_tag_i | input | 4 | Tag of the retiring entry |
| cmt_data_i | input | 32 | Result written into the register file |

## Verification
A corrupted busy bit shows up on the next read of that register. A stale free flag hands a consumer an old register value, and a stuck busy flag sends it to a reorder-buffer entry that has already retired. A wrong tag shows up on the cycle after the rename, at the first read of the register. The stimulus therefore reads each register one cycle after every rename, commit or flush that touches it. This covers out-of-order ownership: two writers in flight, an older writer retiring, and a rename that collides with a commit.

// File: rtl/rename_map_pkg.sv
package rename_map_pkg;

    localparam int RM_NREGS  = 32;
    localparam int RM_TAG_W  = 4;
    localparam int RM_DATA_W = 32;
    localparam int RM_NRD    = 2;

    // Update chosen for one map entry in a cycle
    typedef enum logic [1:0] {
        ENT_HOLD    = 2'd0,
        ENT_CLAIM   = 2'd1,
        ENT_RELEASE = 2'd2,
        ENT_CLEAR   = 2'd3
    } ent_act_e;

endpackage

// File: rtl/rename_map_entry.sv
module rename_map_entry
    import rename_map_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int TAG_W  = RM_TAG_W,
    parameter int DATA_W = RM_DATA_W,
    parameter int ENTRY  = 0
) (
    input  logic              flush_i,
    input  logic              ren_valid_i,
    input  logic [IDX_W-1:0]  ren_idx_i,
    input  logic [TAG_W-1:0]  ren_tag_i,
    input  logic              cmt_valid_i,
    input  logic [IDX_W-1:0]  cmt_idx_i,
    input  logic [TAG_W-1:0]  cmt_tag_i,
    input  logic [DATA_W-1:0] cmt_data_i,
    input  logic              busy_q_i,
    input  logic [TAG_W-1:0]  tag_q_i,
    input  logic [DATA_W-1:0] data_q_i,
    output logic              busy_d_o,
    output logic [TAG_W-1:0]  tag_d_o,
    output logic [DATA_W-1:0] data_d_o
);

    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(ENTRY);

    logic     ren_hit;
    logic     cmt_hit;
    logic     owner_retires;
    ent_act_e act;

    always_comb begin
        ren_hit       = ren_valid_i && (ren_idx_i == MY_IDX);
        cmt_hit       = cmt_valid_i && (cmt_idx_i == MY_IDX);
        owner_retires = cmt_hit && busy_q_i && (tag_q_i == cmt_tag_i);

        // Priority: flush, then the younger rename, then a matching commit
        if (flush_i)            act = ENT_CLEAR;
        else if (ren_hit)       act = ENT_CLAIM;
        else if (owner_retires) act = ENT_RELEASE;
        else                    act = ENT_HOLD;

        busy_d_o = busy_q_i;
        tag_d_o  = tag_q_i;
        unique case (act)
            ENT_CLEAR:   busy_d_o = 1'b0;
            ENT_CLAIM: begin
                busy_d_o = 1'b1;
                tag_d_o  = ren_tag_i;
            end
            ENT_RELEASE: busy_d_o = 1'b0;
            default:     ;
        endcase

        // Retired results always land in the architectural value
        data_d_o = cmt_hit ? cmt_data_i : data_q_i;
    end

endmodule

// File: rtl/rename_map_rdport.sv
module rename_map_rdport #(
    parameter int NREGS  = 32,
    parameter int IDX_W  = 5,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic [NREGS-1:0]             busy_i,
    input  logic [NREGS-1:0][TAG_W-1:0]  tag_i,
    input  logic [NREGS-1:0][DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]             idx_i,
    output logic                         busy_o,
    output logic [TAG_W-1:0]             tag_o,
    output logic [DATA_W-1:0]            data_o
);

    always_comb begin
        busy_o = busy_i[idx_i];
        tag_o  = busy_o ? tag_i[idx_i] : '0;
        data_o = data_i[idx_i];
    end

endmodule

// File: rtl/rename_map.sv
module rename_map
    import rename_map_pkg::*;
#(
    parameter int NREGS  = RM_NREGS,
    parameter int TAG_W  = RM_TAG_W,
    parameter int DATA_W = RM_DATA_W,
    parameter int NRD    = RM_NRD,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          flush_i,
    input  logic [NRD-1:0][IDX_W-1:0]     rs_idx_i,
    output logic [NRD-1:0]                rs_busy_o,
    output logic [NRD-1:0][TAG_W-1:0]     rs_tag_o,
    output logic [NRD-1:0][DATA_W-1:0]    rs_data_o,
    input  logic                          ren_valid_i,
    input  logic [IDX_W-1:0]              ren_idx_i,
    input  logic [TAG_W-1:0]              ren_tag_i,
    input  logic                          cmt_valid_i,
    input  logic [IDX_W-1:0]              cmt_idx_i,
    input  logic [TAG_W-1:0]              cmt_tag_i,
    input  logic [DATA_W-1:0]             cmt_data_i
);

    typedef struct packed {
        logic [NREGS-1:0]             busy;
        logic [NREGS-1:0][TAG_W-1:0]  tag;
        logic [NREGS-1:0][DATA_W-1:0] data;
    } state_t;

    state_t st_d, st_q;

    logic [NREGS-1:0]             busy_q;
    logic [NREGS-1:0][TAG_W-1:0]  tag_q;
    logic [NREGS-1:0][DATA_W-1:0] data_q;

    logic [NREGS-1:0]             ent_busy_d;
    logic [NREGS-1:0][TAG_W-1:0]  ent_tag_d;
    logic [NREGS-1:0][DATA_W-1:0] ent_data_d;

    assign busy_q = st_q.busy;
    assign tag_q  = st_q.tag;
    assign data_q = st_q.data;

    for (genvar e = 0; e < NREGS; e++) begin : g_ent
        rename_map_entry #(
            .IDX_W  (IDX_W),
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W),
            .ENTRY  (e)
        ) ent_i (
            .flush_i     (flush_i),
            .ren_valid_i (ren_valid_i),
            .ren_idx_i   (ren_idx_i),
            .ren_tag_i   (ren_tag_i),
            .cmt_valid_i (cmt_valid_i),
            .cmt_idx_i   (cmt_idx_i),
            .cmt_tag_i   (cmt_tag_i),
            .cmt_data_i  (cmt_data_i),
            .busy_q_i    (busy_q[e]),
            .tag_q_i     (tag_q[e]),
            .data_q_i    (data_q[e]),
            .busy_d_o    (ent_busy_d[e]),
            .tag_d_o     (ent_tag_d[e]),
            .data_d_o    (ent_data_d[e])
        );
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rename_map_rdport #(
            .NREGS  (NREGS),
            .IDX_W  (IDX_W),
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) rd_i (
            .busy_i (busy_q),
            .tag_i  (tag_q),
            .data_i (data_q),
            .idx_i  (rs_idx_i[p]),
            .busy_o (rs_busy_o[p]),
            .tag_o  (rs_tag_o[p]),
            .data_o (rs_data_o[p])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.busy = ent_busy_d;
        st_d.tag  = ent_tag_d;
        st_d.data = ent_data_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
    parameter int NREGS  = 32,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         flush_i,
    input logic                         ren_valid_i,
    input logic [IDX_W-1:0]             ren_idx_i,
    input logic [TAG_W-1:0]             ren_tag_i,
    input logic                         cmt_valid_i,
    input logic [IDX_W-1:0]             cmt_idx_i,
    input logic [TAG_W-1:0]             cmt_tag_i,
    input logic [DATA_W-1:0]            cmt_data_i,
    input logic [NREGS-1:0]             busy_q,
    input logic [NREGS-1:0][TAG_W-1:0]  tag_q,
    input logic [NREGS-1:0][DATA_W-1:0] data_q
);

    logic same_reg;
    assign same_reg = ren_valid_i && (ren_idx_i == cmt_idx_i);

    a_r3_rename_binds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ren_valid_i && !flush_i) |=>
        (busy_q[$past(ren_idx_i)] && tag_q[$past(ren_idx_i)] == $past(ren_tag_i)));

    a_r5_owner_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmt_valid_i && !flush_i && !same_reg && busy_q[cmt_idx_i]
         && tag_q[cmt_idx_i] == cmt_tag_i) |=> !busy_q[$past(cmt_idx_i)]);

    a_r6_younger_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmt_valid_i && !flush_i && !same_reg && busy_q[cmt_idx_i]
         && tag_q[cmt_idx_i] != cmt_tag_i) |=>
        (busy_q[$past(cmt_idx_i)] && tag_q[$past(cmt_idx_i)] == $past(tag_q[cmt_idx_i])));

    a_r8_flush_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (busy_q == '0));

    a_r9_commit_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmt_valid_i |=> (data_q[$past(cmt_idx_i)] == $past(cmt_data_i)));

endmodule

bind rename_map rename_map_chk #(
    .NREGS  (NREGS),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .ren_valid_i (ren_valid_i),
    .ren_idx_i   (ren_idx_i),
    .ren_tag_i   (ren_tag_i),
    .cmt_valid_i (cmt_valid_i),
    .cmt_idx_i   (cmt_idx_i),
    .cmt_tag_i   (cmt_tag_i),
    .cmt_data_i  (cmt_data_i),
    .busy_q      (busy_q),
    .tag_q       (tag_q),
    .data_q      (data_q)
);

// File: tb/rename_map_tb_top.sv
module rename_map_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic             rst_n;
    logic             flush;
    logic [1:0][4:0]  rs_idx;
    logic [1:0]       rs_busy;
    logic [1:0][3:0]  rs_tag;
    logic [1:0][31:0] rs_data;
    logic             ren_v;
    logic [4:0]       ren_idx;
    logic [3:0]       ren_tag;
    logic             cmt_v;
    logic [4:0]       cmt_idx;
    logic [3:0]       cmt_tag;
    logic [31:0]      cmt_data;

    rename_map dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .flush_i     (flush),
        .rs_idx_i    (rs_idx),
        .rs_busy_o   (rs_busy),
        .rs_tag_o    (rs_tag),
        .rs_data_o   (rs_data),
        .ren_valid_i (ren_v),
        .ren_idx_i   (ren_idx),
        .ren_tag_i   (ren_tag),
        .cmt_valid_i (cmt_v),
        .cmt_idx_i   (cmt_idx),
        .cmt_tag_i   (cmt_tag),
        .cmt_data_i  (cmt_data)
    );

    typedef struct packed {
        logic        ren_v;
        logic [4:0]  ren_idx;
        logic [3:0]  ren_tag;
        logic        cmt_v;
        logic [4:0]  cmt_idx;
        logic [3:0]  cmt_tag;
        logic [31:0] cmt_data;
        logic        flush;
        logic [4:0]  rs0;
        logic [4:0]  rs1;
        logic        eb0;
        logic [3:0]  et0;
        logic [31:0] ed0;
        logic        eb1;
        logic [3:0]  et1;
        logic [31:0] ed1;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 13;
    // Reads are compared before the edge that applies the same vector's operations
    localparam vec_t VEC [NVEC] = '{
        // R1 R2: idle reads after reset
        '{1'b0,5'd0,4'd0, 1'b0,5'd0,4'd0,32'h0, 1'b0, 5'd1,5'd2,  1'b0,4'd0,32'h0, 1'b0,4'd0,32'h0, 8'd1},
        // R4 R10: rename r5->3, both ports read r5 and see the old free mapping
        '{1'b1,5'd5,4'd3, 1'b0,5'd0,4'd0,32'h0, 1'b0, 5'd5,5'd5,  1'b0,4'd0,32'h0, 1'b0,4'd0,32'h0, 8'd4},
        // R3: r5 now tag 3; second writer renames r5->7
        '{1'b1,5'd5,4'd7, 1'b0,5'd0,4'd0,32'h0, 1'b0, 5'd5,5'd0,  1'b1,4'd3,32'h0, 1'b0,4'd0,32'h0, 8'd3},
        // R3: younger tag 7 owns r5; older entry 3 retires
        '{1'b0,5'd0,4'd0, 1'b1,5'd5,4'd3,32'h111, 1'b0, 5'd5,5'd6, 1'b1,4'd7,32'h0, 1'b0,4'd0,32'h0, 8'd3},
        // R6: stale commit wrote data but r5 still busy tag 7; rename r6->2
        '{1'b1,5'd6,4'd2, 1'b0,5'd0,4'd0,32'h0, 1'b0, 5'd5,5'd6,  1'b1,4'd7,32'h111, 1'b0,4'd0,32'h0, 8'd6},
        // R5: owner 7 retires r5
        '{1'b0,5'd0,4'd0, 1'b1,5'd5,4'd7,32'h222, 1'b0, 5'd5,5'd6, 1'b1,4'd7,32'h111, 1'b1,4'd2,32'h0, 8'd5},
        // R7: rename r6->9 together with commit of tag 2 on r6
        '{1'b1,5'd6,4'd9, 1'b1,5'd6,4'd2,32'h333, 1'b0, 5'd5,5'd6, 1'b0,4'd0,32'h222, 1'b1,4'd2,32'h0, 8'd5},
        // R7: rename won; rename r8->1
        '{1'b1,5'd8,4'd1, 1'b0,5'd0,4'd0,32'h0, 1'b0, 5'd5,5'd6,  1'b0,4'd0,32'h222, 1'b1,4'd9,32'h333, 8'd7},
        // R8: flush with a rename of r9 in the same cycle
        '{1'b1,5'd9,4'd4, 1'b0,5'd0,4'd0,32'h0, 1'b1, 5'd8,5'd6,  1'b1,4'd1,32'h0, 1'b1,4'd9,32'h333, 8'd8},
        // R8: all free, r9 rename dropped
        '{1'b0,5'd0,4'd0, 1'b0,5'd0,4'd0,32'h0, 1'b0, 5'd8,5'd9,  1'b0,4'd0,32'h0, 1'b0,4'd0,32'h0, 8'd8},
        // R8: r6 keeps committed value; rename top register r31->15
        '{1'b1,5'd31,4'd15, 1'b0,5'd0,4'd0,32'h0, 1'b0, 5'd6,5'd31, 1'b0,4'd0,32'h333, 1'b0,4'd0,32'h0, 8'd8},
        // R9: r31 busy tag 15; flush plus commit into free r0
        '{1'b0,5'd0,4'd0, 1'b1,5'd0,4'd0,32'hABC, 1'b1, 5'd31,5'd0, 1'b1,4'd15,32'h0, 1'b0,4'd0,32'h0, 8'd3},
        // R9: r0 holds the data, r31 freed
        '{1'b0,5'd0,4'd0, 1'b0,5'd0,4'd0,32'h0, 1'b0, 5'd0,5'd31,  1'b0,4'd0,32'hABC, 1'b0,4'd0,32'h0, 8'd9}
    };

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic check(input string what, input int req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ren_v = 1'b0; ren_idx = '0; ren_tag = '0;
        cmt_v = 1'b0; cmt_idx = '0; cmt_tag = '0; cmt_data = '0;
        flush = 1'b0;
    endtask

    task automatic read_chk(input int port, input logic [4:0] idx, input int req,
                            input logic eb, input logic [3:0] et, input logic [31:0] ed);
        rs_idx[port] = idx;
        #1;
        check($sformatf("port%0d r%0d busy", port, idx), req, 32'(rs_busy[port]), 32'(eb));
        check($sformatf("port%0d r%0d tag", port, idx), req, 32'(rs_tag[port]), 32'(et));
        check($sformatf("port%0d r%0d data", port, idx), req, rs_data[port], ed);
    endtask

    initial begin
        rst_n  = 1'b0;
        rs_idx = '0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            ren_v    = VEC[i].ren_v;   ren_idx = VEC[i].ren_idx; ren_tag = VEC[i].ren_tag;
            cmt_v    = VEC[i].cmt_v;   cmt_idx = VEC[i].cmt_idx; cmt_tag = VEC[i].cmt_tag;
            cmt_data = VEC[i].cmt_data;
            flush    = VEC[i].flush;
            rs_idx[0] = VEC[i].rs0;
            rs_idx[1] = VEC[i].rs1;
            #1;
            check($sformatf("vec%0d p0 busy", i), int'(VEC[i].req), 32'(rs_busy[0]), 32'(VEC[i].eb0));
            check($sformatf("vec%0d p0 tag", i),  int'(VEC[i].req), 32'(rs_tag[0]),  32'(VEC[i].et0));
            check($sformatf("vec%0d p0 data", i), int'(VEC[i].req), rs_data[0],      VEC[i].ed0);
            check($sformatf("vec%0d p1 busy", i), int'(VEC[i].req), 32'(rs_busy[1]), 32'(VEC[i].eb1));
            check($sformatf("vec%0d p1 tag", i),  int'(VEC[i].req), 32'(rs_tag[1]),  32'(VEC[i].et1));
            check($sformatf("vec%0d p1 data", i), int'(VEC[i].req), rs_data[1],      VEC[i].ed1);
        end

        // R3: rename r3->5 then read it one cycle later
        @(negedge clk);
        idle();
        ren_v = 1'b1; ren_idx = 5'd3; ren_tag = 4'd5;
        @(negedge clk);
        idle();
        read_chk(0, 5'd3, 3, 1'b1, 4'd5, 32'h0);

        // R1: reset mid-run drops the mapping and committed values
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        read_chk(0, 5'd3, 1, 1'b0, 4'd0, 32'h0);
        read_chk(1, 5'd0, 1, 1'b0, 4'd0, 32'h0);
        read_chk(1, 5'd5, 1, 1'b0, 4'd0, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule